// File: doc/BRIEF.md
# Alternating-Compare PWM Timer Channel

This block is one counter channel that produces a pulse-width modulated output by alternating between two compare registers. The counter advances on each cycle in which an external prescaler presents a count-enable tick. It counts from zero until it equals the active compare value, and then the output flag toggles and the other compare register becomes active. The first compare register sets the length of the low phase and the second sets the length of the high phase. Each holds its phase length in ticks minus one, so a compare value of zero gives a one-tick phase.

Each compare register has a preload register. A preload is copied into its compare register when the opposite compare matches. Software can therefore stage a new period and duty cycle at any time, and the waveform picks up the new values at phase boundaries without a glitch. To get a steady 0% or 100% level, software stops the channel and holds the forced level with the polarity bit. All configuration goes through a single-cycle write port. The channel raises sticky flags for compare 1 match, compare 2 match and counter wrap, and combines them with per-flag enables into one interrupt line. The data width `CNT_W` must be at least 11 so that the control word fits.

Top module: `altcmp_pwm`

## Requirements
- R1: After reset, `pwm_o`, `pwm_oe_o`, all three flags and `irq_o` are 0. Compare 1 is the active register and the counter is stopped, so ticks do not change the output until the channel is started.
- R2: With the reinit bit (control bit 2) set and the up direction selected, writing the run bit (control bit 0) from 0 to 1 clears the counter to 0 and selects compare 1. The output flag then stays low for (compare 1 + 1) ticks and high for (compare 2 + 1) ticks, and the two phases alternate for as long as the channel runs.
- R3: The counter advances only on cycles where `tick_i` is 1 and run is set. With run cleared, the output holds its level.
- R4: When compare 2 matches, preload 1 is copied into compare 1. When compare 1 matches, preload 2 is copied into compare 2. A new pair of preloads therefore takes effect within two phases.
- R5: Control bit 3 inverts the level driven on `pwm_o`. Control bit 4 drives `pwm_oe_o`, and when bit 4 is 0, `pwm_o` is 0.
- R6: Writing control bit 5 as 1 clears the output flag at that clock edge, and this takes priority over a toggle. With run cleared, the forced level stays constant: 0% duty, or 100% duty when the polarity bit is also set.
- R7: Control bit 1 selects down counting. The counter decrements from 0 and wraps, compare 2 is active at start, and each phase lasts ((2^CNT_W − compare) mod 2^CNT_W) + 1 ticks.
- R8: Flag bit 0 is the compare 1 match, bit 1 is the compare 2 match, and bit 2 is counter wrap. Counter wrap means the counter passes the maximum when counting up, or passes 0 when counting down, without a reinit match. Each flag is sticky. Writing 1 to a flag's bit at address 5 clears it, and a flag being set in the same cycle wins over the clear.
- R9: `irq_o` is 1 when any flag is set whose enable is set. The enables are control bits 8 (compare 1), 9 (compare 2) and 10 (wrap).
- R10: Write addresses are: 0 control, 1 compare 1, 2 compare 2, 3 preload 1, 4 preload 2, 5 flag clear. A bus write to a compare register takes effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable from the prescaler |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | CNT_W | Register write data |
| pwm_o | output | 1 | PWM pin level |
| pwm_oe_o | output | 1 | Pin output enable |
| cmp1_flag_o | output | 1 | Sticky compare 1 match flag |
| cmp2_flag_o | output | 1 | Sticky compare 2 match flag |
| ovf_flag_o | output | 1 | Sticky counter wrap flag |
| irq_o | output | 1 | Interrupt request from the enabled flags |

## Verification
The assertions check properties that must hold on every cycle:
- the pin is quiet whenever the output enable is low;
- neither the output nor the flags move on a cycle with no tick and no write;
- flags stay set until a clear write arrives;
- a force write pulls the pin low;
- the interrupt line never rises without a flag behind it.

Phase lengths can only be shown by the bench's scenarios, which measure them. These cover a sweep of small compare pairs, a divided tick, a preload change in the middle of a run, the down-counting formula near the wrap point, and the 0%/100% forced levels.

// File: rtl/altcmp_pkg.sv
package altcmp_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 3'd0,
    REG_CMP1  = 3'd1,
    REG_CMP2  = 3'd2,
    REG_PRE1  = 3'd3,
    REG_PRE2  = 3'd4,
    REG_FLAGS = 3'd5
  } reg_addr_e;

  localparam int B_RUN    = 0;
  localparam int B_DOWN   = 1;
  localparam int B_REINIT = 2;
  localparam int B_POL    = 3;
  localparam int B_OEN    = 4;
  localparam int B_FORCE  = 5;
  localparam int B_IE1    = 8;
  localparam int B_IEOV   = 10;

  localparam int F_C1 = 0;
  localparam int F_C2 = 1;
  localparam int F_OV = 2;

  typedef struct packed {
    logic       run;
    logic       down;
    logic       reinit;
    logic       pol;
    logic       oen;
    logic [2:0] ie;
  } ctrl_t;
endpackage

// File: rtl/altcmp_ctrl.sv
module altcmp_ctrl
  import altcmp_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output ctrl_t            ctrl_o,
  output logic             start_o,
  output logic             start_sel_o,
  output logic             force_o,
  output logic [2:0]       clr_o
);
  ctrl_t ctrl_q;
  logic  wr_ctrl;

  assign wr_ctrl = wr_en_i && (wr_addr_i == REG_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.run    <= wr_data_i[B_RUN];
      ctrl_q.down   <= wr_data_i[B_DOWN];
      ctrl_q.reinit <= wr_data_i[B_REINIT];
      ctrl_q.pol    <= wr_data_i[B_POL];
      ctrl_q.oen    <= wr_data_i[B_OEN];
      ctrl_q.ie     <= wr_data_i[B_IEOV:B_IE1];
    end
  end

  assign ctrl_o      = ctrl_q;
  // start only on a 0->1 transition of run
  assign start_o     = wr_ctrl && wr_data_i[B_RUN] && !ctrl_q.run;
  assign start_sel_o = wr_data_i[B_DOWN];
  assign force_o     = wr_ctrl && wr_data_i[B_FORCE];
  assign clr_o       = (wr_en_i && (wr_addr_i == REG_FLAGS)) ? wr_data_i[2:0] : 3'b000;
endmodule

// File: rtl/altcmp_cmp_bank.sv
module altcmp_cmp_bank
  import altcmp_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [CNT_W-1:0]      wr_data_i,
  input  logic [1:0]            hit_i,
  output logic [1:0][CNT_W-1:0] cmp_o
);
  for (genvar i = 0; i < 2; i++) begin : g_slot
    localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(int'(REG_CMP1) + i);
    localparam logic [ADDR_W-1:0] A_PRE = ADDR_W'(int'(REG_PRE1) + i);

    logic [CNT_W-1:0] cmp_r;
    logic [CNT_W-1:0] pre_r;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pre_r <= '0;
      end else if (wr_en_i && (wr_addr_i == A_PRE)) begin
        pre_r <= wr_data_i;
      end
    end

    // bus write wins over the cross-triggered preload transfer
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cmp_r <= '0;
      end else if (wr_en_i && (wr_addr_i == A_CMP)) begin
        cmp_r <= wr_data_i;
      end else if (hit_i[1-i]) begin
        cmp_r <= pre_r;
      end
    end

    assign cmp_o[i] = cmp_r;
  end
endmodule

// File: rtl/altcmp_core.sv
module altcmp_core
  import altcmp_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  ctrl_t                 ctrl_i,
  input  logic                  start_i,
  input  logic                  start_sel_i,
  input  logic                  force_i,
  input  logic [2:0]            clr_i,
  input  logic [1:0][CNT_W-1:0] cmp_i,
  output logic [1:0]            hit_o,
  output logic                  out_flag_o,
  output logic [2:0]            flags_o
);
  localparam logic [CNT_W-1:0] MAX_V = '1;

  logic [CNT_W-1:0] cnt_q, cnt_nxt, active;
  logic             sel_q, out_q;
  logic [2:0]       flags_q;
  logic             step, hit, bound, wrap;

  assign active  = cmp_i[sel_q];
  assign step    = ctrl_i.run && tick_i && !start_i;
  assign hit     = step && (cnt_q == active);
  assign bound   = ctrl_i.down ? (cnt_q == '0) : (cnt_q == MAX_V);
  assign wrap    = step && bound && !(hit && ctrl_i.reinit);
  assign cnt_nxt = ctrl_i.down ? cnt_q - 1'b1 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      sel_q <= start_sel_i;
    end else if (step) begin
      cnt_q <= (hit && ctrl_i.reinit) ? '0 : cnt_nxt;
      if (hit) sel_q <= ~sel_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      out_q <= 1'b0;
    else if (force_i) out_q <= 1'b0;
    else if (hit)     out_q <= ~out_q;
  end

  // set beats clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr_i) | {wrap, hit && sel_q, hit && !sel_q};
  end

  assign hit_o      = {hit && sel_q, hit && !sel_q};
  assign out_flag_o = out_q;
  assign flags_o    = flags_q;
endmodule

// File: rtl/altcmp_pwm.sv
module altcmp_pwm
  import altcmp_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic              pwm_o,
  output logic              pwm_oe_o,
  output logic              cmp1_flag_o,
  output logic              cmp2_flag_o,
  output logic              ovf_flag_o,
  output logic              irq_o
);
  ctrl_t                 ctrl;
  logic                  start, start_sel, force_lo, out_flag;
  logic [2:0]            clr, flags;
  logic [1:0]            hit;
  logic [1:0][CNT_W-1:0] cmp;

  altcmp_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .ctrl_o     (ctrl),
    .start_o    (start),
    .start_sel_o(start_sel),
    .force_o    (force_lo),
    .clr_o      (clr)
  );

  altcmp_cmp_bank #(.CNT_W(CNT_W)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .hit_i    (hit),
    .cmp_o    (cmp)
  );

  altcmp_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .ctrl_i     (ctrl),
    .start_i    (start),
    .start_sel_i(start_sel),
    .force_i    (force_lo),
    .clr_i      (clr),
    .cmp_i      (cmp),
    .hit_o      (hit),
    .out_flag_o (out_flag),
    .flags_o    (flags)
  );

  assign pwm_o       = ctrl.oen && (out_flag ^ ctrl.pol);
  assign pwm_oe_o    = ctrl.oen;
  assign cmp1_flag_o = flags[F_C1];
  assign cmp2_flag_o = flags[F_C2];
  assign ovf_flag_o  = flags[F_OV];
  assign irq_o       = |(flags & ctrl.ie);
endmodule

// File: rtl/altcmp_pwm_chk.sv
module altcmp_pwm_chk
  import altcmp_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [CNT_W-1:0]  wr_data_i,
  input logic              pwm_o,
  input logic              pwm_oe_o,
  input logic              cmp1_flag_o,
  input logic              cmp2_flag_o,
  input logic              ovf_flag_o,
  input logic              irq_o
);
  logic clr_wr;
  assign clr_wr = wr_en_i && (wr_addr_i == REG_FLAGS);

  // R5
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_oe_o |-> !pwm_o);

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_en_i) |=> ($stable(pwm_o) && $stable(cmp1_flag_o)
                               && $stable(cmp2_flag_o) && $stable(ovf_flag_o)));

  // R8
  c1_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp1_flag_o && !(clr_wr && wr_data_i[F_C1])) |=> cmp1_flag_o);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_flag_o && !(clr_wr && wr_data_i[F_OV])) |=> ovf_flag_o);

  // R6
  force_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_addr_i == REG_CTRL) && wr_data_i[B_FORCE]
     && wr_data_i[B_OEN] && !wr_data_i[B_POL]) |=> !pwm_o);

  // R9
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cmp1_flag_o || cmp2_flag_o || ovf_flag_o));
endmodule

bind altcmp_pwm altcmp_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .pwm_o      (pwm_o),
  .pwm_oe_o   (pwm_oe_o),
  .cmp1_flag_o(cmp1_flag_o),
  .cmp2_flag_o(cmp2_flag_o),
  .ovf_flag_o (ovf_flag_o),
  .irq_o      (irq_o)
);

// File: tb/altcmp_pwm_tb.sv
module altcmp_pwm_tb;
  localparam int W = 16;
  localparam int C_RUN = 1, C_DOWN = 2, C_REINIT = 4, C_POL = 8, C_OEN = 16,
                 C_FORCE = 32, C_IEOV = 1024;

  logic         clk_i = 0, rst_ni = 0, tick_i = 0, wr_en_i = 0;
  logic [2:0]   wr_addr_i = 0;
  logic [W-1:0] wr_data_i = 0;
  logic pwm_o, pwm_oe_o, cmp1_flag_o, cmp2_flag_o, ovf_flag_o, irq_o;

  int n_chk = 0, n_fail = 0, tick_div = 1, div_cnt = 0;
  bit done = 0;

  altcmp_pwm #(.CNT_W(W)) u_dut (.*);

  always #10 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    if (div_cnt >= tick_div - 1) div_cnt = 0;
    else div_cnt++;
    tick_i = (div_cnt == 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk_i);
    wr_en_i = 1; wr_addr_i = 3'(a); wr_data_i = W'(d);
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  // R10 addresses: 0 ctrl, 1/2 compare, 3/4 preload, 5 flag clear
  task automatic setup(input int c1, input int c2, input int mode);
    wr(0, C_FORCE);
    wr(5, 7);
    wr(1, c1); wr(2, c2); wr(3, c1); wr(4, c2);
    wr(0, mode | C_RUN);
  endtask

  task automatic measure(output int hi, output int lo);
    logic prev;
    prev = pwm_o;
    for (int g = 0; g < 5000; g++) begin
      @(negedge clk_i);
      if (!prev && pwm_o) break;
      prev = pwm_o;
    end
    hi = 1;
    for (int g = 0; g < 5000; g++) begin
      @(negedge clk_i);
      if (pwm_o) hi++; else break;
    end
    lo = 1;
    for (int g = 0; g < 5000; g++) begin
      @(negedge clk_i);
      if (!pwm_o) lo++; else break;
    end
  endtask

  function automatic int dn_len(input int c);
    return ((65536 - c) % 65536) + 1;
  endfunction

  initial begin
    #4000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int hi, lo;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk(pwm_o == 0 && pwm_oe_o == 0, "R1 pin", int'(pwm_o), 0);
    chk({cmp1_flag_o, cmp2_flag_o, ovf_flag_o, irq_o} == 0, "R1 flags",
        int'({cmp1_flag_o, cmp2_flag_o, ovf_flag_o, irq_o}), 0);
    wr(0, C_OEN);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk_i);
      chk(pwm_o == 0 && cmp1_flag_o == 0, "R1 stopped", int'(pwm_o), 0);
    end

    // R2 sweep of small compare pairs
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 5; b++) begin
        setup(a, b, C_REINIT | C_OEN);
        measure(hi, lo);
        measure(hi, lo);
        chk(lo == a + 1, "R2 low phase", lo, a + 1);
        chk(hi == b + 1, "R2 high phase", hi, b + 1);
        chk(ovf_flag_o == 0, "R8 no wrap", int'(ovf_flag_o), 0);
        chk(cmp1_flag_o && cmp2_flag_o, "R8 match flags",
            int'({cmp1_flag_o, cmp2_flag_o}), 3);
      end

    // R3 divided tick, then stop holds level
    tick_div = 3;
    setup(2, 1, C_REINIT | C_OEN);
    measure(hi, lo);
    measure(hi, lo);
    chk(lo == 9, "R3 low with tick/3", lo, 9);
    chk(hi == 6, "R3 high with tick/3", hi, 6);
    tick_div = 1;
    wr(0, C_REINIT | C_OEN);
    begin
      logic held;
      held = pwm_o;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk_i);
        chk(pwm_o == held, "R3 stopped holds", int'(pwm_o), int'(held));
      end
    end

    // R4 preload crossing
    setup(3, 3, C_REINIT | C_OEN);
    measure(hi, lo);
    wr(3, 1); wr(4, 5);
    measure(hi, lo);
    measure(hi, lo);
    chk(lo == 2, "R4 new low", lo, 2);
    chk(hi == 6, "R4 new high", hi, 6);

    // R5 polarity and output enable
    setup(1, 3, C_REINIT | C_OEN | C_POL);
    measure(hi, lo);
    measure(hi, lo);
    chk(hi == 2, "R5 inverted high", hi, 2);
    chk(lo == 4, "R5 inverted low", lo, 4);
    setup(1, 3, C_REINIT);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk_i);
      chk(pwm_o == 0 && pwm_oe_o == 0, "R5 oe off", int'({pwm_oe_o, pwm_o}), 0);
    end

    // R6 force while running, then held 0% / 100%
    setup(2, 40, C_REINIT | C_OEN);
    for (int g = 0; g < 200; g++) begin
      @(negedge clk_i);
      if (pwm_o) break;
    end
    wr(0, C_RUN | C_REINIT | C_OEN | C_FORCE);
    chk(pwm_o == 0, "R6 force low", int'(pwm_o), 0);
    wr(0, C_FORCE | C_OEN);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk_i);
      chk(pwm_o == 0, "R6 hold 0%", int'(pwm_o), 0);
    end
    wr(0, C_FORCE | C_OEN | C_POL);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk_i);
      chk(pwm_o == 1, "R6 hold 100%", int'(pwm_o), 1);
    end

    // R7 down counting near the wrap point
    begin
      int c1s[3] = '{65533, 0, 65534};
      int c2s[3] = '{65534, 65535, 65520};
      for (int t = 0; t < 3; t++) begin
        setup(c1s[t], c2s[t], C_DOWN | C_REINIT | C_OEN);
        measure(hi, lo);
        measure(hi, lo);
        chk(lo == dn_len(c2s[t]), "R7 low from compare 2", lo, dn_len(c2s[t]));
        chk(hi == dn_len(c1s[t]), "R7 high from compare 1", hi, dn_len(c1s[t]));
      end
    end

    // R8 wrap flag and selective clear; R9 interrupt enable
    setup(65533, 65534, C_DOWN | C_REINIT | C_OEN | C_IEOV);
    repeat (20) @(negedge clk_i);
    chk(ovf_flag_o == 1, "R8 wrap flag", int'(ovf_flag_o), 1);
    chk(irq_o == 1, "R9 irq enabled", int'(irq_o), 1);
    wr(0, C_FORCE);
    chk(irq_o == 0, "R9 irq masked", int'(irq_o), 0);
    chk(cmp1_flag_o && cmp2_flag_o && ovf_flag_o, "R8 sticky after stop",
        int'({cmp1_flag_o, cmp2_flag_o, ovf_flag_o}), 7);
    wr(5, 1);
    chk({cmp1_flag_o, cmp2_flag_o, ovf_flag_o} == 3'b011, "R8 clear bit 0",
        int'({cmp1_flag_o, cmp2_flag_o, ovf_flag_o}), 3);
    wr(5, 6);
    chk({cmp1_flag_o, cmp2_flag_o, ovf_flag_o} == 3'b000, "R8 clear bits 1,2",
        int'({cmp1_flag_o, cmp2_flag_o, ovf_flag_o}), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule